// File: doc/BRIEF.md
# Receive Error-Bit Policy Unit

This unit sits next to a serial bus receiver. The receiver reports the errors it detects, one pulse per error: a bit-rising error, a short bit period or a long bit period. For each report the unit makes two decisions. The first is whether reception must stop. The second is whether an error bit must be signalled on the shared line. When an error bit is due, the unit asks the line driver to pull the line low for one and a half nominal bit periods. It raises a busy flag for that whole window.

The error-bit decision is applied in layers. On a frame addressed to one device, each error type has its own enable. On a broadcast frame a separate broadcast-suppress bit takes priority:
- When suppress is set, broadcast errors never signal.
- When suppress is clear, a fixed broadcast rule replaces the per-error enables.

Short-period errors on a broadcast frame are never signalled while the receiver is in listen mode. Error detection itself belongs to the receiver and is not part of this unit.

Top module: `rx_errbit_policy`

## Requirements
- R1: `stop_rx_o` is high in the clock after a cycle in which `bre_err_i` and `cfg_stop_on_bre_i` are both high. It is low otherwise, so it is one clock wide for a one-clock error pulse. It is unaffected by an error bit in progress.
- R2: On a non-broadcast frame (`bcast_i`=0), a bit-rising error requests an error bit only when both `cfg_stop_on_bre_i` and `cfg_bre_eb_i` are 1.
- R3: On a non-broadcast frame, a long-period error requests an error bit exactly when `cfg_lbp_eb_i` is 1.
- R4: On a non-broadcast frame, a short-period error always requests an error bit, whatever the setting of `cfg_listen_i`.
- R5: On a broadcast frame with `cfg_bcast_quiet_i`=0, a bit-rising error requests an error bit exactly when `cfg_stop_on_bre_i` is 1, whatever the value of `cfg_bre_eb_i`.
- R6: On a broadcast frame with `cfg_bcast_quiet_i`=0, a long-period error always requests an error bit, whatever the value of `cfg_lbp_eb_i`.
- R7: On a broadcast frame, a short-period error never requests an error bit while `cfg_listen_i`=1. With `cfg_listen_i`=0 and `cfg_bcast_quiet_i`=0, it does request one.
- R8: On a broadcast frame with `cfg_bcast_quiet_i`=1, no error of any kind requests an error bit.
- R9: A granted request drives `line_low_o` and `busy_o` high from the second clock after the error pulse. They stay high for exactly ERR_CLKS = BIT_CLKS*3/2 clocks (12 with the default BIT_CLKS=8) and then go low.
- R10: A request that arrives while an error bit is being driven is dropped. The window neither restarts nor lengthens.
- R11: After reset, `stop_rx_o`, `line_low_o` and `busy_o` are low.
- R12: Errors reported in the same cycle combine. An error bit is requested if any one of them would request it alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bre_err_i | input | 1 | Bit-rising error pulse |
| sbp_err_i | input | 1 | Short bit period error pulse |
| lbp_err_i | input | 1 | Long bit period error pulse |
| bcast_i | input | 1 | Current frame is broadcast |
| cfg_stop_on_bre_i | input | 1 | Stop reception on bit-rising error |
| cfg_bre_eb_i | input | 1 | Error bit enable for bit-rising error |
| cfg_lbp_eb_i | input | 1 | Error bit enable for long-period error |
| cfg_bcast_quiet_i | input | 1 | Suppress all error bits on broadcast frames |
| cfg_listen_i | input | 1 | Listen mode |
| stop_rx_o | output | 1 | One-clock stop-reception pulse |
| line_low_o | output | 1 | Pull the bus line low (error bit) |
| busy_o | output | 1 | Error bit in progress |

## Verification
The hardest situation to bring about is a second error that arrives while an error bit is already on the line. It only arises after a request has been granted and before the fixed window ends. The stimulus first starts an error bit with a long-period error. Three clocks into the window it injects a further error with stop-on-rising enabled. The bench then checks two things: the stop pulse still appears, and the line releases at exactly the original window end. The policy itself is covered by a sweep over all 512 combinations of error pulses, frame kind and configuration bits. Each combination is followed through its full window.

// File: rtl/errbit_pkg.sv
package errbit_pkg;

  localparam int NUM_ERR = 3;

  typedef enum logic [1:0] {
    ERR_RISE  = 2'd0,
    ERR_SHORT = 2'd1,
    ERR_LONG  = 2'd2
  } err_kind_e;

  typedef struct packed {
    logic stop_on_bre;
    logic bre_eb;
    logic lbp_eb;
    logic bcast_quiet;
    logic listen;
  } policy_t;

  // Layered decision for one error kind: broadcast rules override per-error enables.
  function automatic logic lane_wants(input err_kind_e kind, input policy_t p,
                                      input logic bcast);
    logic w;
    w = 1'b0;
    if (bcast && p.bcast_quiet) begin
      w = 1'b0;
    end else begin
      unique case (kind)
        ERR_RISE:  w = p.stop_on_bre && (bcast || p.bre_eb);
        ERR_SHORT: w = !(bcast && p.listen);
        ERR_LONG:  w = bcast || p.lbp_eb;
        default:   w = 1'b0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/errbit_decide.sv
module errbit_decide
  import errbit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_i,
  input  logic               bcast_i,
  input  policy_t            pol_i,
  output logic               stop_q,
  output logic               req_q
);

  logic [NUM_ERR-1:0] want;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_lane
    assign want[i] = err_i[i] && lane_wants(err_kind_e'(i), pol_i, bcast_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      stop_q <= err_i[ERR_RISE] && pol_i.stop_on_bre;
      req_q  <= |want;
    end
  end

  // R8
  bcast_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bcast_i && pol_i.bcast_quiet) |=> !req_q);

  // R7
  listen_short_chk: assert property (@(posedge clk) disable iff (rst)
    (bcast_i && pol_i.listen && !err_i[ERR_RISE] && !err_i[ERR_LONG]) |=> !req_q);

  // R1
  stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> $past(err_i[ERR_RISE]));

  // R4
  short_unicast_chk: assert property (@(posedge clk) disable iff (rst)
    (!bcast_i && err_i[ERR_SHORT]) |=> req_q);

endmodule

// File: rtl/errbit_driver.sv
module errbit_driver #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic low_o
);

  localparam int ERR_CLKS = (BIT_CLKS * 3) / 2;
  localparam int CW       = $clog2(ERR_CLKS + 1);

  logic [CW-1:0] cnt;
  logic [CW:0]   run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_o <= 1'b0;
      cnt   <= '0;
    end else if (!low_o) begin
      if (req_i) begin
        low_o <= 1'b1;
        cnt   <= CW'(ERR_CLKS - 1);
      end
    end else if (cnt == '0) begin
      low_o <= 1'b0;
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  // independent run-length counter for window checks
  always_ff @(posedge clk) begin
    if (rst || !low_o) run_len <= '0;
    else               run_len <= run_len + (CW+1)'(1);
  end

  // R9
  errbit_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(low_o) |-> ($past(run_len) == (CW+1)'(ERR_CLKS - 1)));

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    low_o |-> (run_len < (CW+1)'(ERR_CLKS)));

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(low_o) |-> $past(req_i));

endmodule

// File: rtl/rx_errbit_policy.sv
module rx_errbit_policy
  import errbit_pkg::*;
#(
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bre_err_i,
  input  logic sbp_err_i,
  input  logic lbp_err_i,
  input  logic bcast_i,
  input  logic cfg_stop_on_bre_i,
  input  logic cfg_bre_eb_i,
  input  logic cfg_lbp_eb_i,
  input  logic cfg_bcast_quiet_i,
  input  logic cfg_listen_i,
  output logic stop_rx_o,
  output logic line_low_o,
  output logic busy_o
);

  logic [NUM_ERR-1:0] errs;
  policy_t            pol;
  logic               req;
  logic               low;

  always_comb begin
    errs = '0;
    errs[ERR_RISE]  = bre_err_i;
    errs[ERR_SHORT] = sbp_err_i;
    errs[ERR_LONG]  = lbp_err_i;
  end

  assign pol = '{stop_on_bre: cfg_stop_on_bre_i, bre_eb: cfg_bre_eb_i,
                 lbp_eb: cfg_lbp_eb_i, bcast_quiet: cfg_bcast_quiet_i,
                 listen: cfg_listen_i};

  errbit_decide u_decide (
    .clk    (clk),
    .rst    (rst),
    .err_i  (errs),
    .bcast_i(bcast_i),
    .pol_i  (pol),
    .stop_q (stop_rx_o),
    .req_q  (req)
  );

  errbit_driver #(.BIT_CLKS(BIT_CLKS)) u_driver (
    .clk  (clk),
    .rst  (rst),
    .req_i(req),
    .low_o(low)
  );

  assign line_low_o = low;
  assign busy_o     = low;

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!stop_rx_o && !line_low_o));

endmodule

// File: tb/rx_errbit_policy_bench.sv
`timescale 1ns/1ps
module rx_errbit_policy_bench;

  localparam int BIT_CLKS = 8;
  localparam int N = (BIT_CLKS * 3) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bre, sbp, lbp, bc, stp, bgen, lgen, quiet, lst;
  logic stop_rx, low, busy;
  int   checks = 0;
  int   fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  rx_errbit_policy #(.BIT_CLKS(BIT_CLKS)) u_rx_errbit_policy (
    .clk(clk), .rst(rst), .bre_err_i(bre), .sbp_err_i(sbp), .lbp_err_i(lbp),
    .bcast_i(bc), .cfg_stop_on_bre_i(stp), .cfg_bre_eb_i(bgen),
    .cfg_lbp_eb_i(lgen), .cfg_bcast_quiet_i(quiet), .cfg_listen_i(lst),
    .stop_rx_o(stop_rx), .line_low_o(low), .busy_o(busy));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Policy model written from the requirements R2..R8, R12
  function automatic logic exp_eb(input logic [8:0] v);
    logic r, s, l, b, st, bg, lg, q, li, e;
    {r, s, l, b, st, bg, lg, q, li} = v;
    if (!b)     e = (r & st & bg) | (l & lg) | s;  // R2 R3 R4
    else if (q) e = 1'b0;                          // R8
    else        e = (r & st) | l | (s & ~li);      // R5 R6 R7
    return e;
  endfunction

  initial begin
    {bre, sbp, lbp, bc, stp, bgen, lgen, quiet, lst} = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 stop", stop_rx, 1'b0);
    chk("R11 low", low, 1'b0);
    chk("R11 busy", busy, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // Exhaustive sweep: R1..R9, R12
    for (int v = 0; v < 512; v++) begin
      logic [8:0] vec;
      logic e;
      vec = 9'(v);
      e = exp_eb(vec);
      {bre, sbp, lbp, bc, stp, bgen, lgen, quiet, lst} = vec;
      @(negedge clk);
      {bre, sbp, lbp} = '0;
      chk("R1 stop pulse", stop_rx, vec[8] & vec[4]);
      chk("R9 not yet low", low, 1'b0);
      @(negedge clk);
      chk("R1 one clock", stop_rx, 1'b0);
      for (int k = 0; k < N + 2; k++) begin
        chk("R2-R8 R12 R9 line_low", low, e && (k < N));
        chk("R9 busy", busy, e && (k < N));
        @(negedge clk);
      end
    end

    // R10: second request during window is dropped, stop still pulses (R1)
    {bc, quiet, lst, bgen} = '0;
    lgen = 1'b1; stp = 1'b1;
    lbp = 1'b1;
    @(negedge clk);
    lbp = 1'b0;
    @(negedge clk);
    for (int k = 0; k < N + 3; k++) begin
      if (k == 3) begin bre = 1'b1; sbp = 1'b1; end
      else begin bre = 1'b0; sbp = 1'b0; end
      if (k == 4) chk("R1 stop during error bit", stop_rx, 1'b1);
      chk("R10 window not extended", low, k < N);
      @(negedge clk);
    end
    {bre, sbp} = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule